// File: doc/BRIEF.md
# Packed Access Byte-Enable Generator

This block turns a packed transfer into a series of accesses on a 64-bit data port. A request gives a start byte address, a length counted in elements, and an element size of one, two or four bytes. The block then offers one access per 64-bit word touched by the transfer. Each access has the word-aligned address, an eight-lane byte-enable mask and the number of elements it carries.

Only the first and last accesses can be partly filled. Which lanes are enabled depends on where the start address falls inside its word and on how many bytes are left. Every access between them has all eight lanes enabled. The block only plans the accesses. Moving the data, grouping accesses into bursts and byte swapping are done elsewhere.

A request is taken on a valid/ready handshake. Each access is offered on a second valid/ready handshake. The block pulses `done` when the transfer is complete and pulses `err` when it rejects a request.

Top module: `pack_be_gen`

## Requirements
- R1: After reset, `req_ready` is 1 and `beat_valid`, `done` and `err` are 0.
- R2: `req_esize` encodes the element size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes. The value 3 is rejected in the same way as R3.
- R3: A start address that is not a multiple of the element size produces an `err` pulse in the cycle after the request is taken. No access follows and `done` stays low.
- R4: A request with length zero produces a `done` pulse in the cycle after it is taken, and no access.
- R5: `beat_addr` always has bits [2:0] at zero. Successive accesses of one transfer step by 8.
- R6: In the first access, the lanes from the start offset (address bits [2:0]) are enabled. They run up to lane 7, or up to the last byte of the transfer if that comes earlier. Lane i carries byte address `beat_addr + i`.
- R7: Every access other than the first and the last has `beat_be` = 0xFF.
- R8: In every access after the first, lane 0 is enabled. In the last access, the enabled lanes end at the transfer's last byte.
- R9: `beat_count` equals the number of enabled lanes divided by the element size in bytes. Over one transfer these counts add up to the requested length.
- R10: While `beat_valid` is 1 and `beat_ready` is 0, the access stays offered and `beat_addr`, `beat_be` and `beat_count` do not change.
- R11: `done` pulses for one cycle, in the cycle after the last access is accepted. `req_ready` is 0 from the cycle after the request is taken until that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Transfer length in elements |
| req_esize | input | 2 | Element size code |
| beat_valid | output | 1 | Access offered |
| beat_ready | input | 1 | Access accepted by the consumer |
| beat_addr | output | ADDR_W | Word-aligned access address |
| beat_be | output | 8 | Byte-lane enables |
| beat_count | output | 4 | Elements carried by the access |
| done | output | 1 | One-cycle pulse when the transfer completes |
| err | output | 1 | One-cycle pulse when a request is rejected |

## Verification
The assertions assume that the byte count of a request, length times element size, fits in LEN_W+2 bits. They also assume that the consumer may hold `beat_ready` low for any number of cycles, without needing the block to drop an offer. The stimulus keeps lengths small. It offers a request only when `req_ready` is high, and it drives `beat_ready` from fixed stall patterns so that offers are both accepted at once and held back. Misaligned addresses and the reserved size code are sent only as single requests whose only expected result is the `err` pulse.

// File: rtl/pbg_pkg.sv
package pbg_pkg;
    localparam int LANES = 8;
    localparam int OFF_W = 3;

    typedef enum logic [1:0] {
        ES_BYTE = 2'd0,
        ES_HALF = 2'd1,
        ES_WORD = 2'd2,
        ES_RSVD = 2'd3
    } esize_e;
endpackage

// File: rtl/pbg_lane_mask.sv
module pbg_lane_mask
    import pbg_pkg::*;
(
    input  logic [OFF_W-1:0] first_lane,
    input  logic [OFF_W:0]   n_lanes,
    output logic [LANES-1:0] mask
);
    localparam int SUM_W = OFF_W + 2;

    logic [SUM_W-1:0] end_lane;
    assign end_lane = SUM_W'(first_lane) + SUM_W'(n_lanes);

    // one comparator pair per byte lane
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mask[i] = (SUM_W'(i) >= SUM_W'(first_lane)) && (SUM_W'(i) < end_lane);
    end
endmodule

// File: rtl/pbg_beat_slice.sv
module pbg_beat_slice
    import pbg_pkg::*;
#(
    parameter int REM_W = 18
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [REM_W-1:0] rem_bytes,
    input  logic [1:0]       esize,
    output logic [OFF_W:0]   nbytes,
    output logic [OFF_W:0]   count,
    output logic [LANES-1:0] be
);
    logic [OFF_W:0] room;

    always_comb begin
        room = (OFF_W+1)'(LANES) - (OFF_W+1)'(offset);
        if (rem_bytes < REM_W'(room)) begin
            nbytes = rem_bytes[OFF_W:0];
        end else begin
            nbytes = room;
        end
        count = nbytes >> esize;
    end

    pbg_lane_mask u_mask (
        .first_lane (offset),
        .n_lanes    (nbytes),
        .mask       (be)
    );
endmodule

// File: rtl/pack_be_gen.sv
module pack_be_gen
    import pbg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [1:0]        req_esize,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [ADDR_W-1:0] beat_addr,
    output logic [7:0]        beat_be,
    output logic [3:0]        beat_count,
    output logic              done,
    output logic              err
);
    localparam int REM_W = LEN_W + 2;
    localparam int WA_W  = ADDR_W - OFF_W;

    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] addr;
        logic [REM_W-1:0]  rem;
        logic [1:0]        esz;
        logic              done;
        logic              err;
    } state_t;

    state_t s_d, s_q;

    logic [OFF_W:0]   slice_bytes;
    logic [OFF_W:0]   slice_count;
    logic [LANES-1:0] slice_be;
    logic             misaligned;
    logic             take_req;

    pbg_beat_slice #(.REM_W(REM_W)) u_slice (
        .offset    (s_q.addr[OFF_W-1:0]),
        .rem_bytes (s_q.rem),
        .esize     (s_q.esz),
        .nbytes    (slice_bytes),
        .count     (slice_count),
        .be        (slice_be)
    );

    always_comb begin
        unique case (esize_e'(req_esize))
            ES_BYTE: misaligned = 1'b0;
            ES_HALF: misaligned = req_addr[0];
            ES_WORD: misaligned = |req_addr[1:0];
            default: misaligned = 1'b1;
        endcase
    end

    assign take_req = req_valid && !s_q.busy;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        if (take_req) begin
            if (misaligned) begin
                s_d.err = 1'b1;
            end else if (req_len == '0) begin
                s_d.done = 1'b1;
            end else begin
                s_d.busy = 1'b1;
                s_d.addr = req_addr;
                s_d.esz  = req_esize;
                s_d.rem  = REM_W'(req_len) << req_esize;
            end
        end else if (s_q.busy && beat_ready) begin
            s_d.addr = {s_q.addr[ADDR_W-1:OFF_W] + WA_W'(1), {OFF_W{1'b0}}};
            s_d.rem  = s_q.rem - REM_W'(slice_bytes);
            if (s_q.rem == REM_W'(slice_bytes)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready  = !s_q.busy;
    assign beat_valid = s_q.busy;
    assign beat_addr  = {s_q.addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign beat_be    = slice_be;
    assign beat_count = slice_count;
    assign done       = s_q.done;
    assign err        = s_q.err;

    // R5: offered addresses are word aligned
    a_r5_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (beat_addr[OFF_W-1:0] == '0));

    // R5: consecutive accesses step by one word
    a_r5_step_word: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready) ##1 beat_valid |-> beat_addr == $past(beat_addr) + ADDR_W'(LANES));

    // R10: an offer held back keeps its contents
    a_r10_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) |=> beat_valid && $stable(beat_addr) && $stable(beat_be) && $stable(beat_count));

    // R9: lane count matches element count times element size
    a_r9_count_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> ($countones(beat_be) == (int'(beat_count) << s_q.esz)) && (beat_be != '0));

    // R6: enabled lanes form one contiguous run
    a_r6_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> ((beat_be + (beat_be & (~beat_be + 8'd1))) & beat_be) == 8'd0);

    // R8: accesses after the first start at lane 0
    a_r8_from_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready) ##1 beat_valid |-> beat_be[0]);

    // R11: no new request while a transfer runs; done is a single pulse
    a_r11_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> !req_ready);
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3 R4: completion and rejection never coincide with an offer
    a_r3_err_alone: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !done && !beat_valid);
    a_r4_done_alone: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !beat_valid);
endmodule

// File: tb/pack_be_gen_test.sv
`timescale 1ns/1ps
module pack_be_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic [1:0]  req_esize = '0;
    logic        beat_valid;
    logic        beat_ready = 1'b0;
    logic [31:0] beat_addr;
    logic [7:0]  beat_be;
    logic [3:0]  beat_count;
    logic        done;
    logic        err;

    int checks = 0;
    int errors = 0;

    logic [31:0] ea [128];
    logic [7:0]  eb [128];
    int          ec [128];
    int          en;

    always #4 clk = ~clk;

    pack_be_gen uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_esize(req_esize),
        .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_addr(beat_addr), .beat_be(beat_be), .beat_count(beat_count),
        .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // expected accesses built byte by byte from the lane rule
    task automatic build_expect(input logic [31:0] a, input int len, input logic [1:0] es);
        int eby = 1 << es;
        en = 0;
        for (int k = 0; k < len * eby; k++) begin
            logic [31:0] ba = a + k;
            logic [31:0] w  = {ba[31:3], 3'b000};
            if (en == 0 || ea[en-1] != w) begin
                ea[en] = w;
                eb[en] = 8'h00;
                en++;
            end
            eb[en-1][ba[2:0]] = 1'b1;
        end
        for (int i = 0; i < en; i++) ec[i] = $countones(eb[i]) / eby;
    endtask

    task automatic send_req(input logic [31:0] a, input int len, input logic [1:0] es);
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_addr = a; req_len = 16'(len); req_esize = es;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // R5 R6 R7 R8 R9 R10 R11: one transfer with a stall pattern
    task automatic run_xfer(input logic [31:0] a, input int len, input logic [1:0] es,
                            input logic [7:0] stall);
        int idx = 0;
        int cyc = 0;
        int sum = 0;
        bit hold = 0;
        logic [31:0] pa = '0;
        logic [7:0]  pb = '0;
        logic [3:0]  pc = '0;
        build_expect(a, len, es);
        send_req(a, len, es);
        while (idx < en && cyc < 1000) begin
            logic rdy;
            chk(req_ready == 1'b0, "R11", "ready low while busy", 32'(req_ready), 32'd0);
            if (hold) begin
                chk(beat_valid && beat_addr == pa && beat_be == pb && beat_count == pc,
                    "R10", "held offer changed", {beat_addr[23:0], beat_be}, {pa[23:0], pb});
            end
            rdy = !stall[cyc % 8];
            beat_ready = rdy;
            chk(beat_valid == 1'b1, "R11", "offer present", 32'(beat_valid), 32'd1);
            if (beat_valid) begin
                if (rdy) begin
                    chk(beat_addr == ea[idx], "R5", "address", beat_addr, ea[idx]);
                    chk(beat_be == eb[idx], idx == 0 ? "R6" : (idx == en-1 ? "R8" : "R7"),
                        "byte enables", 32'(beat_be), 32'(eb[idx]));
                    chk(int'(beat_count) == ec[idx], "R9", "element count",
                        32'(beat_count), 32'(ec[idx]));
                    sum += int'(beat_count);
                    idx++;
                end
                hold = !rdy;
                pa = beat_addr; pb = beat_be; pc = beat_count;
            end
            @(negedge clk);
            cyc++;
        end
        beat_ready = 1'b0;
        chk(sum == len, "R9", "elements total", 32'(sum), 32'(len));
        chk(done == 1'b1, "R11", "done after last", 32'(done), 32'd1);
        chk(beat_valid == 1'b0, "R11", "no offer after last", 32'(beat_valid), 32'd0);
        @(negedge clk);
        chk(done == 1'b0 && req_ready == 1'b1, "R11", "done single pulse",
            {30'd0, done, req_ready}, 32'd1);
    endtask

    task automatic run_zero(input logic [31:0] a);
        send_req(a, 0, 2'd0);
        chk(done == 1'b1, "R4", "done for zero length", 32'(done), 32'd1);
        chk(beat_valid == 1'b0 && err == 1'b0, "R4", "no offer for zero length",
            {30'd0, beat_valid, err}, 32'd0);
        @(negedge clk);
        chk(done == 1'b0 && beat_valid == 1'b0, "R4", "quiet after zero length",
            {30'd0, done, beat_valid}, 32'd0);
    endtask

    task automatic run_reject(input logic [31:0] a, input logic [1:0] es, input string req);
        send_req(a, 4, es);
        chk(err == 1'b1, req, "err pulse", 32'(err), 32'd1);
        chk(beat_valid == 1'b0 && done == 1'b0, req, "nothing else on reject",
            {30'd0, beat_valid, done}, 32'd0);
        @(negedge clk);
        chk(err == 1'b0 && beat_valid == 1'b0 && req_ready == 1'b1, req, "idle after reject",
            {29'd0, err, beat_valid, req_ready}, 32'd1);
    endtask

    task automatic run_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
        chk(beat_valid == 1'b0 && done == 1'b0 && err == 1'b0, "R1", "outputs after reset",
            {29'd0, beat_valid, done, err}, 32'd0);
    endtask

    initial begin
        #(8ns * 200000);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        run_reset();
        run_xfer(32'h100, 16, 2'd0, 8'h00);   // R7 two full words
        run_xfer(32'h103, 20, 2'd0, 8'h00);   // R6 R8 offset start, ragged end
        run_xfer(32'h202, 3, 2'd0, 8'h00);    // R6 short within one word
        run_xfer(32'h306, 6, 2'd1, 8'h00);    // R2 halfwords
        run_xfer(32'h404, 3, 2'd2, 8'h00);    // R2 words
        run_xfer(32'h507, 30, 2'd0, 8'hA6);   // R10 backpressure
        run_xfer(32'h60C, 5, 2'd2, 8'h0F);    // R10 long stalls
        run_zero(32'h123);                    // R4
        run_reject(32'h101, 2'd1, "R3");      // odd address, halfwords
        run_reject(32'h206, 2'd2, "R3");      // word size, offset 2
        run_reject(32'h300, 2'd3, "R2");      // reserved size code
        run_xfer(32'h700, 1, 2'd0, 8'h00);    // R8 single byte
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule